// File: doc/BRIEF.md
# Receive Line Alarm Monitor

This block watches one port's recovered receive stream after clock recovery and before any line decoding. For every bit period it gets a positive-mark input, a negative-mark input and a bit enable. From these it finds four kinds of line condition: runs of zeros, loss of the incoming carrier, an unframed all-ones (alarm indication) signal, and bipolar violations. One mode input picks E1 or T1 thresholds. A second input says that the line carries zero-substitution codes, so that the violations those codes create on purpose are not counted as errors.

Each condition sets a sticky bit in a five-bit status vector. A clear strobe empties the vector. The interrupt output is raised while any status bit whose enable is set is 1. Carrier loss and the alarm indication signal also appear as live levels, and each counted violation gives a one-cycle strobe. A bit period with the enable low changes no state.

Top module: `line_alarm_monitor`

## Requirements
- R1: While reset is held and just after it is released, status, irq, carrier_loss, ais_active and bpv_strobe are all 0.
- R2: Status bit 0 (zero run) sets in the cycle after the bit that completes a run of at least 4 consecutive zeros in E1 mode (t1_mode=0), or at least 8 in T1 mode (t1_mode=1). A bit is a zero when both mark_pos and mark_neg are 0. A shorter run sets nothing.
- R3: Status bit 1 sets on a run of 16 consecutive zeros in either mode.
- R4: carrier_loss rises, and status bit 2 sets, after 255 consecutive zeros, or after 2048 when alt_cl_limit=1. One fewer zero leaves it low. It falls in the cycle after the next mark.
- R5: In E1 mode the bits are taken in back-to-back 512-bit windows counted from reset. At the end of each window, ais_active becomes 1 if the window held fewer than two zeros and becomes 0 otherwise. When it becomes 1, status bit 3 sets.
- R6: In T1 mode the windows are 4632 bits long, and ais_active becomes 1 when a window held five zeros or fewer. A change of t1_mode restarts the window.
- R7: A mark with the same polarity as the previous mark is a bipolar violation. It pulses bpv_strobe and sets status bit 4. mark_pos high means positive polarity, and it wins when both inputs are high. The first mark after reset is never a violation.
- R8: With zs_aware=1 in E1 mode, a violation preceded by exactly two or three zeros is not counted.
- R9: With zs_aware=1 in T1 mode, a violation preceded by exactly three zeros is not counted. Neither is one preceded by exactly one zero, if the mark before it followed such an excused violation directly and kept the alternation. With zs_aware=0 every violation counts.
- R10: Status bits stay set until clr_status is high for a cycle. An event in that same cycle keeps its bit set.
- R11: irq is 1 exactly when some status bit is 1 and its irq_enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One received bit is present this cycle |
| mark_pos | input | 1 | Positive mark in this bit |
| mark_neg | input | 1 | Negative mark in this bit |
| t1_mode | input | 1 | 0 selects E1 thresholds, 1 selects T1 thresholds |
| zs_aware | input | 1 | Line uses zero substitution; do not count its violations |
| alt_cl_limit | input | 1 | Carrier-loss threshold of 2048 zeros instead of 255 |
| clr_status | input | 1 | Clear all sticky status bits |
| irq_enable | input | 5 | Per-bit interrupt enables |
| status | output | 5 | Sticky flags: 0 zero run, 1 sixteen zeros, 2 carrier loss, 3 AIS, 4 violation |
| irq | output | 1 | OR of the enabled status bits |
| carrier_loss | output | 1 | Live carrier-loss state |
| ais_active | output | 1 | Live all-ones alarm from the last complete window |
| bpv_strobe | output | 1 | One-cycle pulse per counted violation |

## Verification
The checker properties hold on every cycle. Carrier loss is only present while the zero run has reached the shorter limit, and it is gone after any mark. A violation strobe or a new zero-run flag always traces back to a received bit of the right kind. Status bits never drop without a clear, and irq stays low when no bit is set or every bit is masked. The exact thresholds, the window lengths and zero counts for the alarm signal, and the substitution patterns that are excused can only be shown by the bench's scenarios. Those scenarios drive runs that end one bit short of each limit and one bit past it.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam int ST_W    = 5;
  localparam int ST_ZD   = 0;
  localparam int ST_Z16  = 1;
  localparam int ST_CL   = 2;
  localparam int ST_AIS  = 3;
  localparam int ST_BPV  = 4;

  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_B    = 2'd1,
    ARM_V    = 2'd2
  } arm_e;
endpackage

// File: rtl/lam_zero_run.sv
module lam_zero_run #(
  parameter int ZD_E1    = 4,
  parameter int ZD_T1    = 8,
  parameter int Z16_LEN  = 16,
  parameter int CL_SHORT = 255,
  parameter int CL_LONG  = 2048,
  parameter int RUN_W    = $clog2(CL_LONG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             mark,
  input  logic             t1_mode,
  input  logic             alt_cl_limit,
  output logic [RUN_W-1:0] run_cnt,
  output logic             zd_evt,
  output logic             z16_evt,
  output logic             cl_active,
  output logic             cl_evt
);
  logic [RUN_W-1:0] run_q, run_nxt, zd_thr, cl_thr;
  logic             cl_q;

  function automatic logic [RUN_W-1:0] run_step(input logic [RUN_W-1:0] cur,
                                                 input logic mk);
    if (mk)    return '0;
    if (&cur)  return cur;
    return cur + 1'b1;
  endfunction

  always_comb begin
    run_nxt = run_step(run_q, mark);
    zd_thr  = t1_mode ? RUN_W'(ZD_T1) : RUN_W'(ZD_E1);
    cl_thr  = alt_cl_limit ? RUN_W'(CL_LONG) : RUN_W'(CL_SHORT);
  end

  assign zd_evt  = bit_en && !mark && (run_nxt >= zd_thr);
  assign z16_evt = bit_en && !mark && (run_nxt >= RUN_W'(Z16_LEN));
  assign cl_evt  = bit_en && !mark && !cl_q && (run_nxt >= cl_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      cl_q  <= 1'b0;
    end else if (bit_en) begin
      run_q <= run_nxt;
      if (mark)                  cl_q <= 1'b0;
      else if (run_nxt >= cl_thr) cl_q <= 1'b1;
    end
  end

  assign run_cnt   = run_q;
  assign cl_active = cl_q;
endmodule

// File: rtl/lam_ais_window.sv
module lam_ais_window #(
  parameter int E1_WIN  = 512,
  parameter int T1_WIN  = 4632,
  parameter int E1_MAXZ = 1,
  parameter int T1_MAXZ = 5,
  parameter int WC_W    = $clog2(T1_WIN),
  parameter int ZC_W    = $clog2(T1_MAXZ + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic mark,
  input  logic t1_mode,
  output logic ais_active,
  output logic ais_evt
);
  logic [WC_W-1:0] wc_q, wc_last;
  logic [ZC_W-1:0] zc_q, zc_nxt, zc_max;
  logic            mode_q, ais_q, restart, win_end, all_ones;

  function automatic logic [ZC_W-1:0] zc_step(input logic [ZC_W-1:0] cur,
                                               input logic zero);
    if (!zero || (&cur)) return cur;
    return cur + 1'b1;
  endfunction

  always_comb begin
    wc_last  = t1_mode ? WC_W'(T1_WIN - 1) : WC_W'(E1_WIN - 1);
    zc_max   = t1_mode ? ZC_W'(T1_MAXZ) : ZC_W'(E1_MAXZ);
    restart  = (t1_mode != mode_q);
    zc_nxt   = zc_step(zc_q, !mark);
    win_end  = bit_en && !restart && (wc_q == wc_last);
    all_ones = (zc_nxt <= zc_max);
  end

  assign ais_evt = win_end && all_ones;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q   <= '0;
      zc_q   <= '0;
      mode_q <= 1'b0;
      ais_q  <= 1'b0;
    end else if (restart) begin
      wc_q   <= '0;
      zc_q   <= '0;
      mode_q <= t1_mode;
      ais_q  <= 1'b0;
    end else if (bit_en) begin
      if (win_end) begin
        wc_q  <= '0;
        zc_q  <= '0;
        ais_q <= all_ones;
      end else begin
        wc_q <= wc_q + 1'b1;
        zc_q <= zc_nxt;
      end
    end
  end

  assign ais_active = ais_q;
endmodule

// File: rtl/lam_bpv_check.sv
module lam_bpv_check
  import lam_pkg::*;
#(
  parameter int RUN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             mark_pos,
  input  logic             mark_neg,
  input  logic             t1_mode,
  input  logic             zs_aware,
  input  logic [RUN_W-1:0] zeros_before,
  output logic             bpv_evt
);
  logic have_last_q, last_pos_q, mark, pol_pos, viol, excused, e1_ok, t1_ok;
  arm_e arm_q, arm_nxt;

  function automatic logic zeros_is(input logic [RUN_W-1:0] z, input int n);
    return z == RUN_W'(n);
  endfunction

  always_comb begin
    mark    = mark_pos | mark_neg;
    pol_pos = mark_pos;
    viol    = have_last_q && (pol_pos == last_pos_q);
    e1_ok   = zeros_is(zeros_before, 2) || zeros_is(zeros_before, 3);
    t1_ok   = zeros_is(zeros_before, 3) ||
              ((arm_q == ARM_V) && zeros_is(zeros_before, 1));
    excused = zs_aware && viol && (t1_mode ? t1_ok : e1_ok);
    arm_nxt = ARM_IDLE;
    if (t1_mode && excused && zeros_is(zeros_before, 3))
      arm_nxt = ARM_B;
    else if ((arm_q == ARM_B) && !viol && zeros_is(zeros_before, 0))
      arm_nxt = ARM_V;
  end

  assign bpv_evt = bit_en && mark && viol && !excused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last_q <= 1'b0;
      last_pos_q  <= 1'b0;
      arm_q       <= ARM_IDLE;
    end else if (bit_en && mark) begin
      have_last_q <= 1'b1;
      last_pos_q  <= pol_pos;
      arm_q       <= arm_nxt;
    end
  end
endmodule

// File: rtl/lam_status_reg.sv
module lam_status_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  input  logic [N-1:0] enable,
  output logic [N-1:0] status,
  output logic         irq
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= evt[g] | (bit_q & ~clr);
    end
    assign status[g] = bit_q;
  end

  assign irq = |(status & enable);
endmodule

// File: rtl/line_alarm_monitor.sv
module line_alarm_monitor
  import lam_pkg::*;
#(
  parameter int ZD_E1    = 4,
  parameter int ZD_T1    = 8,
  parameter int Z16_LEN  = 16,
  parameter int CL_SHORT = 255,
  parameter int CL_LONG  = 2048,
  parameter int E1_WIN   = 512,
  parameter int T1_WIN   = 4632,
  parameter int E1_MAXZ  = 1,
  parameter int T1_MAXZ  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            mark_pos,
  input  logic            mark_neg,
  input  logic            t1_mode,
  input  logic            zs_aware,
  input  logic            alt_cl_limit,
  input  logic            clr_status,
  input  logic [ST_W-1:0] irq_enable,
  output logic [ST_W-1:0] status,
  output logic            irq,
  output logic            carrier_loss,
  output logic            ais_active,
  output logic            bpv_strobe
);
  localparam int RUN_W = $clog2(CL_LONG + 1);

  logic             mark;
  logic [RUN_W-1:0] run_cnt;
  logic             zd_evt, z16_evt, cl_evt, ais_evt, bpv_evt, bpv_q;
  logic [ST_W-1:0]  events;

  assign mark = mark_pos | mark_neg;

  lam_zero_run #(
    .ZD_E1(ZD_E1), .ZD_T1(ZD_T1), .Z16_LEN(Z16_LEN),
    .CL_SHORT(CL_SHORT), .CL_LONG(CL_LONG), .RUN_W(RUN_W)
  ) u_zero_run (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark(mark),
    .t1_mode(t1_mode), .alt_cl_limit(alt_cl_limit),
    .run_cnt(run_cnt), .zd_evt(zd_evt), .z16_evt(z16_evt),
    .cl_active(carrier_loss), .cl_evt(cl_evt)
  );

  lam_ais_window #(
    .E1_WIN(E1_WIN), .T1_WIN(T1_WIN), .E1_MAXZ(E1_MAXZ), .T1_MAXZ(T1_MAXZ)
  ) u_ais (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark(mark),
    .t1_mode(t1_mode), .ais_active(ais_active), .ais_evt(ais_evt)
  );

  lam_bpv_check #(.RUN_W(RUN_W)) u_bpv (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .mark_pos(mark_pos), .mark_neg(mark_neg),
    .t1_mode(t1_mode), .zs_aware(zs_aware),
    .zeros_before(run_cnt), .bpv_evt(bpv_evt)
  );

  always_comb begin
    events         = '0;
    events[ST_ZD]  = zd_evt;
    events[ST_Z16] = z16_evt;
    events[ST_CL]  = cl_evt;
    events[ST_AIS] = ais_evt;
    events[ST_BPV] = bpv_evt;
  end

  lam_status_reg #(.N(ST_W)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(events), .clr(clr_status),
    .enable(irq_enable), .status(status), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bpv_q <= 1'b0;
    else        bpv_q <= bpv_evt;
  end
  assign bpv_strobe = bpv_q;

  logic zeros_ge_short;
  assign zeros_ge_short = (run_cnt >= RUN_W'(CL_SHORT));
endmodule

// File: rtl/lam_checker.sv
module lam_checker
  import lam_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bit_en,
  input logic            mark_pos,
  input logic            mark_neg,
  input logic            clr_status,
  input logic [ST_W-1:0] irq_enable,
  input logic [ST_W-1:0] status,
  input logic            irq,
  input logic            carrier_loss,
  input logic            bpv_strobe,
  input logic            zeros_ge_short
);
  // R4: carrier loss only while the zero run is at least the short limit
  a_r4_cl_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_loss |-> zeros_ge_short);

  // R4: any received mark ends carrier loss
  a_r4_cl_clears_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (mark_pos || mark_neg)) |=> !carrier_loss);

  // R7: a violation strobe follows a received mark
  a_r7_bpv_needs_mark: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_strobe |-> $past(bit_en && (mark_pos || mark_neg)));

  // R2: the zero-run flag only rises after a received zero
  a_r2_zd_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_ZD]) |-> $past(bit_en && !(mark_pos || mark_neg)));

  // R10: without a clear no status bit falls
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_status |=> ((status & $past(status)) == $past(status)));

  // R11: no interrupt without a set status bit or with all enables off
  a_r11_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == '0) || (irq_enable == '0)) |-> !irq);
endmodule

bind line_alarm_monitor lam_checker u_lam_checker (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
  .mark_pos(mark_pos), .mark_neg(mark_neg), .clr_status(clr_status),
  .irq_enable(irq_enable), .status(status), .irq(irq),
  .carrier_loss(carrier_loss), .bpv_strobe(bpv_strobe),
  .zeros_ge_short(zeros_ge_short)
);

// File: tb/line_alarm_monitor_bench.sv
`timescale 1ns/1ps
module line_alarm_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, mark_pos = 1'b0, mark_neg = 1'b0;
  logic       t1_mode = 1'b0, zs_aware = 1'b0, alt_cl_limit = 1'b0;
  logic       clr_status = 1'b0;
  logic [4:0] irq_enable = 5'b0;
  logic [4:0] status;
  logic       irq, carrier_loss, ais_active, bpv_strobe;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  pol = 1'b1;

  always #2 clk = ~clk;

  line_alarm_monitor u_line_alarm_monitor (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .mark_pos(mark_pos), .mark_neg(mark_neg),
    .t1_mode(t1_mode), .zs_aware(zs_aware), .alt_cl_limit(alt_cl_limit),
    .clr_status(clr_status), .irq_enable(irq_enable),
    .status(status), .irq(irq), .carrier_loss(carrier_loss),
    .ais_active(ais_active), .bpv_strobe(bpv_strobe)
  );

  // {t1, zs, len[4:0], pattern[31:0], expected status[4:0]}
  // pattern symbol k: bit 2k = positive mark, bit 2k+1 = negative mark
  localparam logic [43:0] VEC [0:13] = '{
    {1'b0, 1'b0, 5'd4,  32'h0000_0099, 5'b00000},  // R7 alternating, no flag
    {1'b0, 1'b0, 5'd2,  32'h0000_0005, 5'b10000},  // R7 two positives
    {1'b0, 1'b1, 5'd5,  32'h0000_0101, 5'b00000},  // R8 000V excused
    {1'b0, 1'b1, 5'd3,  32'h0000_0011, 5'b10000},  // R8 one zero counts
    {1'b0, 1'b1, 5'd5,  32'h0000_0209, 5'b00000},  // R8 B00V excused
    {1'b0, 1'b0, 5'd6,  32'h0000_0801, 5'b00001},  // R2 four zeros E1
    {1'b1, 1'b0, 5'd6,  32'h0000_0801, 5'b00000},  // R2 four zeros T1
    {1'b1, 1'b1, 5'd9,  32'h0001_8901, 5'b00000},  // R9 full substitution
    {1'b1, 1'b1, 5'd3,  32'h0000_0011, 5'b10000},  // R9 lone one-zero V
    {1'b0, 1'b0, 5'd16, 32'h0000_0000, 5'b00011},  // R3 sixteen zeros
    {1'b1, 1'b0, 5'd8,  32'h0000_0000, 5'b00001},  // R2 eight zeros T1
    {1'b1, 1'b0, 5'd7,  32'h0000_0000, 5'b00000},  // R2 seven zeros T1
    {1'b1, 1'b0, 5'd5,  32'h0000_0101, 5'b10000},  // R9 not aware counts
    {1'b0, 1'b0, 5'd3,  32'h0000_0000, 5'b00000}   // R2 three zeros E1
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic t1, input logic zs, input logic alt);
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; mark_pos = 1'b0; mark_neg = 1'b0;
    clr_status = 1'b0; t1_mode = t1; zs_aware = zs; alt_cl_limit = alt;
    pol = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic p, input logic n);
    @(negedge clk);
    bit_en = 1'b1; mark_pos = p; mark_neg = n;
  endtask

  task automatic send_mark();
    send(pol, !pol);
    pol = !pol;
  endtask

  task automatic idle();
    @(negedge clk);
    bit_en = 1'b0; mark_pos = 1'b0; mark_neg = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    check("R1 status in reset", int'(status), 0);
    do_reset(1'b0, 1'b0, 1'b0);
    check("R1 status after reset", int'(status), 0);
    check("R1 irq after reset", int'(irq), 0);
    check("R1 carrier_loss after reset", int'(carrier_loss), 0);
    check("R1 ais_active after reset", int'(ais_active), 0);
    check("R1 bpv_strobe after reset", int'(bpv_strobe), 0);

    // vector table
    for (int i = 0; i < 14; i++) begin
      logic [43:0] v;
      logic [31:0] pat;
      int len;
      v   = VEC[i];
      pat = v[36:5];
      len = int'(v[41:37]);
      do_reset(v[43], v[42], 1'b0);
      for (int k = 0; k < len; k++) send(pat[2*k], pat[2*k+1]);
      idle();
      check($sformatf("R2/R3/R7/R8/R9 vector %0d", i), int'(status), int'(v[4:0]));
    end

    // R7 strobe timing: second positive mark gives a pulse one cycle later
    do_reset(1'b0, 1'b0, 1'b0);
    send(1'b1, 1'b0);
    send(1'b1, 1'b0);
    idle();
    check("R7 bpv_strobe pulse", int'(bpv_strobe), 1);
    @(negedge clk);
    check("R7 bpv_strobe one cycle", int'(bpv_strobe), 0);

    // R4 short carrier-loss limit
    do_reset(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 254; k++) send(1'b0, 1'b0);
    idle();
    check("R4 254 zeros no loss", int'(carrier_loss), 0);
    send(1'b0, 1'b0);
    idle();
    check("R4 255 zeros loss", int'(carrier_loss), 1);
    check("R4 status bit 2", int'(status[2]), 1);
    send_mark();
    idle();
    check("R4 mark ends loss", int'(carrier_loss), 0);
    check("R10 carrier bit stays", int'(status[2]), 1);

    // R4 long limit
    do_reset(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 2047; k++) send(1'b0, 1'b0);
    idle();
    check("R4 2047 zeros no loss", int'(carrier_loss), 0);
    send(1'b0, 1'b0);
    idle();
    check("R4 2048 zeros loss", int'(carrier_loss), 1);

    // R5 E1 windows
    do_reset(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 512; k++) begin
      if (k == 100) send(1'b0, 1'b0); else send_mark();
    end
    idle();
    check("R5 one zero gives AIS", int'(ais_active), 1);
    check("R5 AIS status", int'(status), 5'b01000);
    for (int k = 0; k < 512; k++) begin
      if (k == 50 || k == 300) send(1'b0, 1'b0); else send_mark();
    end
    idle();
    check("R5 two zeros clear AIS", int'(ais_active), 0);

    // R11 masking and R10 clear
    irq_enable = 5'b10111;
    @(negedge clk);
    check("R11 masked bit no irq", int'(irq), 0);
    irq_enable = 5'b01000;
    @(negedge clk);
    check("R11 enabled bit irq", int'(irq), 1);
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    check("R10 clear empties status", int'(status), 0);
    check("R11 irq after clear", int'(irq), 0);
    irq_enable = 5'b0;

    // R6 T1 windows
    do_reset(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4632; k++) begin
      if ((k % 1000) == 7) send(1'b0, 1'b0); else send_mark();
    end
    idle();
    check("R6 five zeros gives AIS", int'(ais_active), 1);
    for (int k = 0; k < 4632; k++) begin
      if ((k % 800) == 7) send(1'b0, 1'b0); else send_mark();
    end
    idle();
    check("R6 six zeros clear AIS", int'(ais_active), 0);
    check("R6 AIS status sticky", int'(status), 5'b01000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule